// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Keyed Write Lock

This block is a memory-mapped watchdog that sits on a simple 32-bit register bus. A down-counter runs on the core clock while the block is enabled. When the counter runs out the first time, the block raises a level interrupt and starts counting again from the programmed load value. If software services the interrupt, the watchdog starts a fresh period. If the counter runs out again while the interrupt is still pending, the block drives a fixed-width reset pulse, provided reset generation has been armed.

Every write to a register other than the lock register is thrown away unless the block has first been unlocked with a 32-bit key. Software unlocks the block, changes the load value or the control bits, or services the interrupt, and then locks it again with any other value. Reads are always allowed. The read data is a combinational function of the address.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the block is locked and both control bits are 0. The load register and the live count both read 0xFFFFFFFF, no interrupt is pending, and both `irq` and `wdt_rst` are low.
- R2: A write of 0x1ACCE551 to the lock register (offset 0xC00) unlocks the block. A write of any other value locks it. While the block is locked, a write to any other offset changes nothing.
- R3: In the control register (offset 0x008), bit 0 enables counting and the interrupt output, and bit 1 arms reset generation. Bits 31:2 always read as zero.
- R4: An accepted write of any value to the service register (offset 0x00C) clears the pending interrupt and loads the count from the load register (offset 0x000) at the same clock edge. This write takes priority over counting.
- R5: `wdt_rst` rises only after an expiry at which the interrupt was already pending and bit 1 of the control register was set. The first expiry only sets the pending flag.
- R6: With bit 1 of the control register clear, a second expiry leaves the interrupt pending and produces no reset.
- R7: While the block is enabled, the count drops by one each clock edge. At an edge where the count is zero, the count reloads from the load register and the pending flag is set. With load value L, the period is therefore L+1 edges.
- R8: While bit 0 of the control register is clear, the count holds its value. Setting bit 0 again resumes counting from that value.
- R9: `wdt_rst` stays high for exactly PULSE_LEN (16) cycles. At the edge where it falls, both control bits and the pending flag return to 0. Expiries that occur during the pulse do not restart it.
- R10: `irq` is high exactly when an interrupt is pending and bit 0 of the control register is set. The status register (offset 0x014) reads 1 while the interrupt is pending, whatever the state of bit 0.
- R11: The live count register (offset 0x004) is read-only, so a write to it has no effect. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: pending and enabled |
| wdt_rst | output | 1 | Reset pulse after the second unserviced expiry |

## Verification
Each accepted write takes effect at the rising edge during which `bus_wr` is high. Its effect can be read back through the combinational read port one nanosecond after the next falling edge. The bench therefore drives and samples only at falling edges. It counts edges from the one that enables the counter: with load L, the count after k edges is L minus (k mod (L+1)), and the pending flag is set once k reaches L+1. The reset pulse is due at edge 2(L+1). It must stay high through edge 2(L+1)+15, and at the following edge the pulse, the control bits and the pending flag must all be clear. Expected values follow from these formulas and are compared at every edge of each window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 12;

  // Offsets decoded by software
  localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_SVC   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'hC00;

  localparam logic [BUS_W-1:0] OPEN_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic rst_arm;  // bit 1
    logic run;      // bit 0
  } wd_ctrl_t;

  function automatic logic key_matches(input logic [BUS_W-1:0] d);
    return d == OPEN_KEY;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              expire,
  input  logic              pulse_done,
  output logic              locked,
  output logic [CNT_W-1:0]  load_q,
  output wd_ctrl_t          ctrl_q,
  output logic              pend_q,
  output logic              svc_hit
);
  logic wr_ok;

  assign wr_ok   = bus_wr && !locked && (bus_addr != OFF_LOCK);
  assign svc_hit = wr_ok && (bus_addr == OFF_SVC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
      load_q <= '1;
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFF_LOCK)
        locked <= !key_matches(bus_wdata);
      if (wr_ok && bus_addr == OFF_LOAD)
        load_q <= bus_wdata[CNT_W-1:0];
      if (pulse_done)
        ctrl_q <= '0;
      else if (wr_ok && bus_addr == OFF_CTRL)
        ctrl_q <= '{rst_arm: bus_wdata[1], run: bus_wdata[0]};
      if (pulse_done || svc_hit)
        pend_q <= 1'b0;
      else if (expire)
        pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] c,
    input logic [CNT_W-1:0] l,
    input logic             go,
    input logic             rl
  );
    if (rl)        return l;
    if (!go)       return c;
    if (c == '0)   return l;
    return c - CNT_W'(1);
  endfunction

  assign expire = run && !reload && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= next_count(cnt_q, load_val, run, reload);
  end
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic rst_out,
  output logic done
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LAST = PW'(PULSE_LEN - 1);

  logic          active_q;
  logic [PW-1:0] idx_q;

  assign rst_out = active_q;
  assign done    = active_q && (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (!active_q) begin
      if (trigger) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end
    end else if (done) begin
      active_q <= 1'b0;
    end else begin
      idx_q <= idx_q + PW'(1);
    end
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        wdt_rst
);
  logic             locked;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt_q;
  wd_ctrl_t         ctrl_q;
  logic             ctrl_run;
  logic             ctrl_arm;
  logic             pend_q;
  logic             svc_hit;
  logic             expire;
  logic             second_expiry;
  logic             pulse_done;

  assign ctrl_run = ctrl_q.run;
  assign ctrl_arm = ctrl_q.rst_arm;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .expire(expire), .pulse_done(pulse_done),
    .locked(locked), .load_q(load_q), .ctrl_q(ctrl_q), .pend_q(pend_q),
    .svc_hit(svc_hit)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_run), .reload(svc_hit),
    .load_val(load_q), .cnt_q(cnt_q), .expire(expire)
  );

  assign second_expiry = expire && pend_q && ctrl_arm;

  wdog_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trigger(second_expiry),
    .rst_out(wdt_rst), .done(pulse_done)
  );

  assign irq = pend_q && ctrl_run;

  always_comb begin
    case (bus_addr)
      OFF_LOAD:  bus_rdata = BUS_W'(load_q);
      OFF_COUNT: bus_rdata = BUS_W'(cnt_q);
      OFF_CTRL:  bus_rdata = BUS_W'({ctrl_arm, ctrl_run});
      OFF_STAT:  bus_rdata = BUS_W'(pend_q);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              locked,
  input logic [CNT_W-1:0]  load_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              ctrl_run,
  input logic              ctrl_arm,
  input logic              pend_q,
  input logic              svc_hit,
  input logic              expire,
  input logic              wdt_rst
);
  localparam int HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= '0;
    else if (wdt_rst) hi_len <= hi_len + HW'(1);
    else              hi_len <= '0;
  end

  AST_LOCKED_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_wr && bus_addr == OFF_LOAD) |=> $stable(load_q)); // R2
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_CTRL) |-> (bus_rdata[BUS_W-1:2] == '0)); // R3
  AST_SVC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hit |=> (cnt_q == $past(load_q) && !pend_q)); // R4
  AST_RST_NEEDS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(expire && pend_q && ctrl_arm)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_run && !svc_hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R7
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_run && !svc_hit) |=> $stable(cnt_q)); // R8
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst) |-> (hi_len == HW'(PULSE_LEN))); // R9
  AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    hi_len <= HW'(PULSE_LEN)); // R9
  AST_POST_PULSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst) |-> (!ctrl_run && !ctrl_arm && !pend_q)); // R9
endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .locked(locked), .load_q(load_q), .cnt_q(cnt_q),
  .ctrl_run(ctrl_run), .ctrl_arm(ctrl_arm), .pend_q(pend_q),
  .svc_hit(svc_hit), .expire(expire), .wdt_rst(wdt_rst)
);

// File: tb/wdog_twostage_tb.sv
module wdog_twostage_tb;
  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                          A_SVC = 12'h00C, A_STAT = 12'h014, A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wdt_rst;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  wdog_twostage u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdt_rst(wdt_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_cnt(input int l, input int k);
    return 32'(l - (k % (l + 1)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: power-on state
    rd(A_LOAD, v); check("R1 load", v, 32'hFFFFFFFF);
    rd(A_CNT, v);  check("R1 count", v, 32'hFFFFFFFF);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);
    check("R1 rst", wdt_rst, 0);
    wr(A_LOAD, 5);
    rd(A_LOAD, v); check("R1 starts locked", v, 32'hFFFFFFFF);

    // R2: key unlocks, other value relocks
    wr(A_LOCK, KEY);
    wr(A_LOAD, 5);
    rd(A_LOAD, v); check("R2 unlocked write", v, 5);
    wr(A_LOCK, KEY ^ 32'h1);
    wr(A_LOAD, 9);
    rd(A_LOAD, v); check("R2 relocked write ignored", v, 5);
    wr(A_CTRL, 1);
    rd(A_CTRL, v); check("R2 ctrl locked", v, 0);
    wr(A_LOCK, KEY);

    // R3: reserved bits read zero
    wr(A_CTRL, 32'hFFFFFFFC);
    rd(A_CTRL, v); check("R3 reserved", v, 0);
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, v); check("R3 arm bit", v, 2);
    wr(A_CTRL, 0);

    // R11: count read-only, unmapped reads zero
    wr(A_CNT, 32'h55);
    rd(A_CNT, v); check("R11 count ro", v, 32'hFFFFFFFF);
    rd(12'h010, v); check("R11 unmapped", v, 0);

    // R7, R6, R10: period sweep without reset arming
    for (int l = 0; l <= 6; l++) begin
      wr(A_CTRL, 0);
      wr(A_LOAD, 32'(l));
      wr(A_SVC, 1);
      wr(A_CTRL, 1);
      for (int k = 0; k <= 2 * l + 4; k++) begin
        rd(A_CNT, v);  check("R7 count", v, exp_cnt(l, k));
        rd(A_STAT, v); check("R7 pending", v, (k >= l + 1) ? 1 : 0);
        check("R10 irq", irq, (k >= l + 1) ? 1 : 0);
        check("R6 no reset", wdt_rst, 0);
        @(negedge clk);
      end
    end

    // R8: freeze and resume
    wr(A_CTRL, 0);
    wr(A_LOAD, 20);
    wr(A_SVC, 1);
    wr(A_CTRL, 1);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 0);
    rd(A_CNT, v); check("R8 stop edge", v, 14);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); check("R8 frozen", v, 14);
    wr(A_CTRL, 1);
    rd(A_CNT, v); check("R8 resume edge", v, 14);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); check("R8 resumed", v, 11);

    // R4, R5: service prevents reset
    wr(A_CTRL, 0);
    wr(A_LOAD, 3);
    wr(A_SVC, 1);
    wr(A_CTRL, 3);
    repeat (4) @(negedge clk);
    check("R5 first expiry irq", irq, 1);
    check("R5 first expiry no rst", wdt_rst, 0);
    wr(A_SVC, 32'hDEAD);
    rd(A_STAT, v); check("R4 cleared", v, 0);
    rd(A_CNT, v);  check("R4 reloaded", v, 3);
    repeat (3) @(negedge clk);
    rd(A_CNT, v);  check("R4 count after service", v, 0);
    repeat (1) @(negedge clk);
    rd(A_STAT, v); check("R5 pending again", v, 1);
    check("R5 no rst after service", wdt_rst, 0);
    wr(A_CTRL, 0);

    // R10: pending visible with counting stopped, irq gated
    check("R10 irq gated", irq, 0);
    rd(A_STAT, v); check("R10 status held", v, 1);

    // R2: service write while locked is ignored
    wr(A_LOCK, 0);
    wr(A_SVC, 1);
    rd(A_STAT, v); check("R2 locked service", v, 1);
    wr(A_LOCK, KEY);

    // R5, R9: unserviced second expiry gives 16-cycle pulse
    wr(A_SVC, 1);
    wr(A_CTRL, 3);
    for (int k = 0; k <= 26; k++) begin
      check("R9 pulse", wdt_rst, (k >= 8 && k <= 23) ? 1 : 0);
      check("R10 irq in pulse run", irq, (k >= 4 && k <= 23) ? 1 : 0);
      if (k == 24) begin
        rd(A_CTRL, v); check("R9 ctrl cleared", v, 0);
        rd(A_STAT, v); check("R9 pending cleared", v, 0);
      end
      if (k == 26) begin
        rd(A_CNT, v); check("R9 counter stopped", v, 3);
      end
      @(negedge clk);
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule